// File: doc/BRIEF.md
# UART Receive Idle Timeout

This block watches the byte-ready strobe of a UART receiver and decides when the line has gone quiet. Every accepted byte strobe clears an internal tick counter and sets it running. If the counter then reaches the programmed idle limit before another byte comes in, the block raises a one-cycle stop-receive pulse. The receiver uses that pulse to close the current buffer early instead of waiting for it to fill.

The idle limit is about twenty bit-times expressed in base-clock ticks. It is derived from the receiver's fractional baud-rate register value B, which encodes baud × 2^32 / 16,000,000. The limit is floor(2^31 / floor(B / 40)). It is computed once per baud-rate load by a sequential divider. While the divider is working, the counter keeps using the previous limit. The receive-complete strobe and a low enable both halt the counter without a pulse. An idle flag marks that the line timed out and stays set until the next accepted byte.

Top module: `rx_idle_guard`

## Requirements
- R1: After reset, stop_rx and idle are 0 and the counter is halted. No stop_rx pulse occurs until a byte strobe has been accepted. The idle limit out of reset is the parameter DEF_TIMEOUT (default 2774).
- R2: A one-cycle baud_load with value B sets the idle limit to T = floor(2^31 / floor(B / 40)). When floor(B / 40) is 0, T is 0xFFFFFFFF. The new limit takes effect 33 clock edges after the load edge, and at that same edge the counter is cleared.
- R3: A byte strobe accepted at edge E (byte_rdy=1 with en=1) clears the counter and starts it. If nothing else happens, stop_rx is first high after edge E+T+1.
- R4: stop_rx is high for exactly one cycle. In the same step the counter is cleared and halted, so no further pulse comes until the next accepted byte strobe.
- R5: rx_end=1 halts the counter without a pulse. While en=0, the counter is halted and byte strobes are ignored. A later accepted byte strobe restarts the normal timing.
- R6: idle rises in the same cycle as stop_rx. It stays at 1 until the next accepted byte strobe, which clears it at that edge.
- R7: A byte strobe accepted while a division is in progress, including in the load cycle itself, is timed with the limit that was in force before the load.
- R8: When a division completes while the counter is running, the counter restarts from 0 with the new limit. stop_rx then appears T_new+1 edges after the completion edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock, one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Detector enable; low halts the counter and blocks byte strobes |
| baud_load | input | 1 | One-cycle strobe that starts a new idle-limit computation |
| baud_val | input | W | Fractional baud-rate register value, sampled on baud_load |
| byte_rdy | input | 1 | Received-byte-ready strobe from the UART |
| rx_end | input | 1 | Receive-buffer-complete strobe; halts the counter |
| stop_rx | output | 1 | One-cycle stop-receive request on idle timeout |
| idle | output | 1 | Line timed out; cleared by the next accepted byte |

## Verification
The assertions assume that control strobes are synchronous single-cycle levels sampled at the clock edge. They also assume that baud_val only matters in the cycle baud_load is high, since the divider captures its operand there. The bench drives every input on the falling edge and holds each strobe for exactly one cycle. It reloads the baud value only after the 33-edge latency, except in the tests that deliberately overlap a load with a byte strobe or with a running count. Those overlap tests check that the old limit governs the count until the completion edge and that the counter is cleared there.

// File: rtl/rxidle_pkg.sv
package rxidle_pkg;
  // Command issued to the tick counter each cycle.
  typedef enum logic [1:0] {
    CMD_HOLD    = 2'd0,
    CMD_RESTART = 2'd1,
    CMD_HALT    = 2'd2
  } cnt_cmd_e;
endpackage

// File: rtl/rxidle_div.sv
// Restoring divider, one quotient bit per cycle.
module rxidle_div #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot
);
  localparam int unsigned SW = $clog2(W + 1);

  logic [W-1:0]  rem_q, q_q, den_q;
  logic [SW-1:0] step_q;
  logic          busy_q, done_q;
  logic [W:0]    shifted, diff;
  logic          fits;

  assign shifted = {rem_q, q_q[W-1]};
  assign fits    = shifted >= {1'b0, den_q};
  assign diff    = shifted - {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      q_q    <= '0;
      den_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start) begin
      rem_q  <= '0;
      q_q    <= num;
      den_q  <= den;
      step_q <= SW'(W);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      rem_q  <= fits ? diff[W-1:0] : shifted[W-1:0];
      q_q    <= {q_q[W-2:0], fits};
      step_q <= step_q - SW'(1);
      if (step_q == SW'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quot = q_q;

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/rxidle_cnt.sv
// Retriggerable tick counter with timeout compare.
module rxidle_cnt
  import rxidle_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cnt_cmd_e     cmd,
  input  logic         reload,
  input  logic [W-1:0] limit,
  output logic         stop_o,
  output logic         idle_o
);
  logic [W-1:0] cnt_q;
  logic         run_q, stop_q, idle_q;
  logic         hit;

  // Compare event: the running counter has reached the limit.
  assign hit = run_q && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      stop_q <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      stop_q <= 1'b0;
      if (cmd == CMD_RESTART) begin
        cnt_q  <= '0;
        run_q  <= 1'b1;
        idle_q <= 1'b0;
      end else if (cmd == CMD_HALT) begin
        run_q <= 1'b0;
        if (reload) cnt_q <= '0;
      end else if (reload) begin
        cnt_q <= '0;
      end else if (hit) begin
        cnt_q  <= '0;
        run_q  <= 1'b0;
        stop_q <= 1'b1;
        idle_q <= 1'b1;
      end else if (run_q) begin
        cnt_q <= cnt_q + W'(1);
      end
    end
  end

  assign stop_o = stop_q;
  assign idle_o = idle_q;

  p_no_pulse_unarmed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !stop_q);
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RESTART) |=> (run_q && cnt_q == '0 && !stop_q));
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> !stop_q);
  p_stop_halts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> (!run_q && cnt_q == '0));
  p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_HALT) |=> (!run_q && !stop_q));
  p_idle_with_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> idle_q);
  p_reload_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && cmd != CMD_RESTART) |=> (cnt_q == '0 && !stop_q));
endmodule

// File: rtl/rx_idle_guard.sv
module rx_idle_guard
  import rxidle_pkg::*;
#(
  parameter int unsigned W           = 32,
  parameter int unsigned BIT_PAIRS   = 40,
  parameter int unsigned DEF_TIMEOUT = 2774
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         baud_load,
  input  logic [W-1:0] baud_val,
  input  logic         byte_rdy,
  input  logic         rx_end,
  output logic         stop_rx,
  output logic         idle
);
  localparam logic [W-1:0] NUMER = W'(1) << (W - 1);

  // Baud register value to the divisor of the idle-limit division.
  function automatic logic [W-1:0] baud_to_den(input logic [W-1:0] b);
    return b / W'(BIT_PAIRS);
  endfunction

  logic         byte_go, halt_req;
  cnt_cmd_e     cmd;
  logic         div_busy, div_done;
  logic [W-1:0] div_quot, limit_q;

  assign byte_go  = en && byte_rdy;
  assign halt_req = !en || rx_end;
  assign cmd      = byte_go ? CMD_RESTART : (halt_req ? CMD_HALT : CMD_HOLD);

  rxidle_div #(.W(W)) div_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (baud_load),
    .num   (NUMER),
    .den   (baud_to_den(baud_val)),
    .busy  (div_busy),
    .done  (div_done),
    .quot  (div_quot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        limit_q <= W'(DEF_TIMEOUT);
    else if (div_done) limit_q <= div_quot;
  end

  rxidle_cnt #(.W(W)) cnt_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd),
    .reload (div_done),
    .limit  (limit_q),
    .stop_o (stop_rx),
    .idle_o (idle)
  );

  p_limit_stable_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (div_busy && !div_done) |=> $stable(limit_q));
  p_byte_clears_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_go |=> !idle);
  p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !stop_rx);
endmodule

// File: tb/rx_idle_guard_tb.sv
module rx_idle_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic        baud_load = 1'b0;
  logic [31:0] baud_val = '0;
  logic        byte_rdy = 1'b0;
  logic        rx_end = 1'b0;
  logic        stop_rx, idle;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  rx_idle_guard dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .baud_load(baud_load),
    .baud_val(baud_val), .byte_rdy(byte_rdy), .rx_end(rx_end),
    .stop_rx(stop_rx), .idle(idle)
  );

  // Baud values and the idle limit each one must give.
  localparam int NV = 5;
  localparam logic [31:0] V_BAUD [NV] = '{32'hF000_0000, 32'h8000_0000,
                                          32'h4000_0000, 32'h2000_0000, 32'hFFFF_FFFF};
  localparam int V_T [NV] = '{21, 40, 80, 160, 20};

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_baud(input logic [31:0] b);
    @(negedge clk); baud_val = b; baud_load = 1'b1;
    @(negedge clk); baud_load = 1'b0;
    idle_cycles(40);
  endtask

  // Strobe byte and/or load on one edge, then count edges to the first stop_rx.
  task automatic measure(input bit do_byte, input bit do_load, input logic [31:0] b,
                         input int limit, output int n);
    @(negedge clk);
    byte_rdy = do_byte; baud_load = do_load;
    if (do_load) baud_val = b;
    @(negedge clk);
    byte_rdy = 1'b0; baud_load = 1'b0;
    n = -1;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (stop_rx) begin n = k; break; end
    end
  endtask

  task automatic count_pulses(input int cycles, output int p);
    p = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (stop_rx) p++;
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n, p;
    idle_cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stop_rx after reset", stop_rx, 0);
    chk("R1 idle after reset", idle, 0);
    count_pulses(200, p);
    chk("R1 no pulse before first byte", p, 0);

    // Default limit from reset.
    measure(1, 0, 0, 4000, n);
    chk("R1 R3 default limit timing", n, 2775);
    @(negedge clk);
    chk("R4 pulse lasts one cycle", stop_rx, 0);
    chk("R6 idle held after timeout", idle, 1);
    count_pulses(3000, p);
    chk("R4 no second pulse", p, 0);
    @(negedge clk); byte_rdy = 1'b1;
    @(negedge clk); byte_rdy = 1'b0;
    chk("R6 byte clears idle", idle, 0);
    rx_end = 1'b1; @(negedge clk); rx_end = 1'b0;

    // Table of baud values.
    for (int v = 0; v < NV; v++) begin
      load_baud(V_BAUD[v]);
      measure(1, 0, 0, 400, n);
      chk($sformatf("R2 R3 limit for baud %h", V_BAUD[v]), n, V_T[v] + 1);
      idle_cycles(3);
    end

    // Zero divisor saturates the limit.
    load_baud(32'd10);
    measure(1, 0, 0, 1000, n);
    chk("R2 zero divisor gives no pulse", n, -1);
    pulse(rx_end);

    // Byte during a pending division uses the old limit.
    load_baud(32'hF000_0000);
    measure(1, 1, 32'h8000_0000, 400, n);
    chk("R7 old limit while dividing", n, 22);
    idle_cycles(40);
    measure(1, 0, 0, 400, n);
    chk("R7 new limit after division", n, 41);

    // rx_end and enable halt the counter.
    @(negedge clk); byte_rdy = 1'b1;
    @(negedge clk); byte_rdy = 1'b0;
    idle_cycles(5);
    pulse(rx_end);
    count_pulses(100, p);
    chk("R5 rx_end halts without pulse", p, 0);
    @(negedge clk); en = 1'b0; byte_rdy = 1'b1;
    @(negedge clk); byte_rdy = 1'b0;
    count_pulses(100, p);
    chk("R5 byte ignored while disabled", p, 0);
    en = 1'b1;
    @(negedge clk); byte_rdy = 1'b1;
    @(negedge clk); byte_rdy = 1'b0;
    idle_cycles(5);
    en = 1'b0;
    count_pulses(100, p);
    chk("R5 disable halts running count", p, 0);
    en = 1'b1;
    measure(1, 0, 0, 400, n);
    chk("R5 restart after halt", n, 41);

    // Division completes while counting: counter restarts with new limit.
    load_baud(32'h4000_0000);
    @(negedge clk); byte_rdy = 1'b1;
    @(negedge clk); byte_rdy = 1'b0;
    idle_cycles(5);
    measure(0, 1, 32'h8000_0000, 400, n);
    chk("R8 restart on completion", n, 74);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule